// File: doc/BRIEF.md
# Memory-Mapped Serial Port Controller

This block is the host-facing side of a byte-oriented serial port. A simple register bus (select, write flag, byte address, write data, registered read data) reaches a small file of word registers. Received bytes enter on a byte strobe and are kept in a circular queue of 32-bit words. Software drains the queue through a data register, and a read of that register when the queue is empty yields all ones. A write to the same register sends its low byte out on a transmit strobe. The line framing and the DMA data movers are outside the block. The block only holds the DMA base addresses, issues start and cancel pulses to the movers, and takes in the receive mover's remaining-byte count as a status input.

One interrupt line is a level. It combines three sources through a three-bit enable mask: queue not empty, transmit DMA (which always counts as complete), and receive DMA idle (remaining count zero). The receive side tells the sender how much it may still accept. That credit is the free queue space while no receive DMA is in flight, and the mover's remaining count while one is.

Top module: `sport_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the block shows: interrupt low, credit equal to the queue capacity, no read-valid, no transmit strobe, no DMA pulses, overflow flag clear.
- R2: The register index is address bits 11..2. Index 0 returns the ID parameter and index 8 returns the queue capacity. Any index other than 0..8 reads as zero, and a write to it changes no register, output or queue state.
- R3: A read of index 1 with a non-empty queue removes the oldest entry and returns it as the received byte, zero-extended. Every read returns its data with read-valid high in the cycle after the access.
- R4: A read of index 1 with an empty queue returns 0xFFFFFFFF and leaves the occupancy at zero.
- R5: Index 2 returns the number of queued entries. When the receive DMA remaining input is zero, the credit output equals capacity minus occupancy. Otherwise the credit equals that remaining input.
- R6: A received byte is stored only while the receive DMA remaining input is zero. At any other time it leaves the queue untouched.
- R7: A byte that arrives while the queue holds capacity entries is dropped (even if a pop happens in the same cycle) and sets an overflow flag that stays set until reset. The entries already held are kept.
- R8: A write of index 1 raises the transmit strobe for exactly one cycle, in the cycle after the access, carrying write-data bits 7..0.
- R9: Index 3 holds a three-bit enable mask (bit 0 queue not empty, bit 1 transmit DMA, bit 2 receive DMA idle) and reads it back zero-extended. The interrupt is high when bit 1 is set, or bit 0 is set with a non-empty queue, or bit 2 is set with the remaining input zero.
- R10: Index 4 holds the transmit DMA address. A write of index 5 pulses the transmit start for one cycle with the written length and the address held before the write, and then advances index 4 by that length. Index 5 always reads zero.
- R11: A write of index 6 stores the receive DMA address, which drives the receive address output, and pulses the cancel output for one cycle. A write of index 7 pulses the receive start with the written length. A read of index 7 returns the remaining input.
- R12: The queue wraps around its storage, so first-in first-out order holds over any number of pushes and pops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address; bits 11..2 pick the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_credit | output | 32 | Bytes the receive side can still take |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_byte | output | 8 | Transmit byte |
| dma_tx_go | output | 1 | Transmit DMA start pulse |
| dma_tx_addr | output | 32 | Transmit DMA base for the current start |
| dma_tx_len | output | 32 | Transmit DMA length for the current start |
| dma_rx_go | output | 1 | Receive DMA start pulse |
| dma_rx_addr | output | 32 | Receive DMA address register |
| dma_rx_len | output | 32 | Receive DMA length for the current start |
| dma_rx_cancel | output | 1 | Receive DMA cancel pulse |
| dma_rx_left | input | 32 | Bytes the receive mover still expects |
| irq | output | 1 | Level interrupt |
| rx_overflow | output | 1 | Sticky dropped-byte flag |

## Verification
The properties assume that reset is held for at least two clock edges and that the bus address is meaningful whenever select is high. They also assume that the remaining-count input moves only between edges, because the interrupt and the credit follow it without a register. The stimulus drives every input away from the rising edge and holds reset for several cycles. It changes the remaining count only at falling edges, so the combinational outputs have settled before each comparison. The test sequence pushes bytes into a full queue only through the receive strobe and does so while the remaining count is zero, which is the one case in which a drop should set the overflow flag.

// File: rtl/sport_pkg.sv
package sport_pkg;

    localparam int IDX_W = 10;
    localparam int IEN_W = 3;

    localparam int IEN_FIFO  = 0;
    localparam int IEN_TXDMA = 1;
    localparam int IEN_RXDMA = 2;

    localparam logic [31:0] EMPTY_WORD = 32'hFFFF_FFFF;

    typedef enum logic [IDX_W-1:0] {
        RIX_ID    = 10'd0,
        RIX_DATA  = 10'd1,
        RIX_LEVEL = 10'd2,
        RIX_IEN   = 10'd3,
        RIX_TXADR = 10'd4,
        RIX_TXCNT = 10'd5,
        RIX_RXADR = 10'd6,
        RIX_RXCNT = 10'd7,
        RIX_CAP   = 10'd8
    } reg_idx_e;

    typedef struct packed {
        logic             sel;
        logic             wr;
        logic [IDX_W-1:0] idx;
        logic [31:0]      wdata;
    } bus_req_t;

    typedef struct packed {
        logic        go;
        logic [31:0] addr;
        logic [31:0] len;
    } dma_cmd_t;

    function automatic logic irq_level(input logic [IEN_W-1:0] en,
                                       input logic fifo_nonempty,
                                       input logic rx_dma_idle);
        return (en[IEN_FIFO] & fifo_nonempty) | en[IEN_TXDMA] |
               (en[IEN_RXDMA] & rx_dma_idle);
    endfunction

endpackage

// File: rtl/sport_rxq.sv
module sport_rxq #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [7:0]    push_byte,
    input  logic          pop,
    output logic [31:0]   head,
    output logic [CW-1:0] level,
    output logic          ovf
);
    localparam int  PW   = $clog2(DEPTH);
    localparam bit  POW2 = (DEPTH & (DEPTH - 1)) == 0;
    localparam logic [CW-1:0] CAP = CW'(DEPTH);

    logic [31:0]   mem [DEPTH];
    logic [PW-1:0] rd_q;
    logic [PW-1:0] wr_slot;
    logic [CW-1:0] lvl_q;
    logic          ovf_q;
    logic          full;
    logic          do_push;
    logic          do_pop;

    assign full    = (lvl_q == CAP);
    assign do_pop  = pop && (lvl_q != '0);
    assign do_push = push && !full;

    generate
        if (POW2) begin : g_wrap_mask
            assign wr_slot = rd_q + lvl_q[PW-1:0];
        end else begin : g_wrap_sub
            logic [PW:0] sum;
            assign sum     = {1'b0, rd_q} + (PW+1)'(lvl_q);
            assign wr_slot = (sum >= (PW+1)'(DEPTH)) ? PW'(sum - (PW+1)'(DEPTH))
                                                     : PW'(sum);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_slot] <= {24'b0, push_byte};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            lvl_q <= '0;
            ovf_q <= 1'b0;
        end else begin
            if (do_pop) begin
                rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   lvl_q <= lvl_q + 1'b1;
                2'b01:   lvl_q <= lvl_q - 1'b1;
                default: lvl_q <= lvl_q;
            endcase
            if (push && full) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign head  = mem[rd_q];
    assign level = lvl_q;
    assign ovf   = ovf_q;

endmodule

// File: rtl/sport_regs.sv
module sport_regs
    import sport_pkg::*;
#(
    parameter int          DEPTH    = 16,
    parameter int          CW       = $clog2(DEPTH + 1),
    parameter logic [31:0] ID_VALUE = 32'h5E71_0001
) (
    input  logic             clk,
    input  logic             rst,
    input  bus_req_t         req,
    input  logic [CW-1:0]    level,
    input  logic [31:0]      head,
    input  logic [31:0]      rx_left,
    output logic             fifo_pop,
    output logic [31:0]      rdata,
    output logic             rvalid,
    output logic [IEN_W-1:0] ien,
    output logic             tx_valid,
    output logic [7:0]       tx_byte,
    output dma_cmd_t         tx_cmd,
    output dma_cmd_t         rx_cmd,
    output logic             rx_cancel
);
    logic             rd_acc;
    logic             wr_acc;
    logic [31:0]      rmux;
    logic [IEN_W-1:0] ien_q;
    logic [31:0]      txaddr_q;
    logic [31:0]      rxaddr_q;
    logic             txgo_q;
    logic [31:0]      txbase_q;
    logic [31:0]      txlen_q;
    logic             rxgo_q;
    logic [31:0]      rxlen_q;
    logic             cancel_q;

    assign rd_acc   = req.sel && !req.wr;
    assign wr_acc   = req.sel && req.wr;
    assign fifo_pop = rd_acc && (req.idx == RIX_DATA);

    always_comb begin
        case (req.idx)
            RIX_ID:    rmux = ID_VALUE;
            RIX_DATA:  rmux = (level != '0) ? head : EMPTY_WORD;
            RIX_LEVEL: rmux = 32'(level);
            RIX_IEN:   rmux = 32'(ien_q);
            RIX_TXADR: rmux = txaddr_q;
            RIX_TXCNT: rmux = 32'd0;
            RIX_RXADR: rmux = rxaddr_q;
            RIX_RXCNT: rmux = rx_left;
            RIX_CAP:   rmux = 32'(DEPTH);
            default:   rmux = 32'd0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata    <= '0;
            rvalid   <= 1'b0;
            tx_valid <= 1'b0;
            tx_byte  <= '0;
            ien_q    <= '0;
            txaddr_q <= '0;
            rxaddr_q <= '0;
            txgo_q   <= 1'b0;
            txbase_q <= '0;
            txlen_q  <= '0;
            rxgo_q   <= 1'b0;
            rxlen_q  <= '0;
            cancel_q <= 1'b0;
        end else begin
            rvalid   <= rd_acc;
            tx_valid <= 1'b0;
            txgo_q   <= 1'b0;
            rxgo_q   <= 1'b0;
            cancel_q <= 1'b0;
            if (rd_acc) begin
                rdata <= rmux;
            end
            if (wr_acc) begin
                case (req.idx)
                    RIX_DATA: begin
                        tx_valid <= 1'b1;
                        tx_byte  <= req.wdata[7:0];
                    end
                    RIX_IEN:   ien_q <= req.wdata[IEN_W-1:0];
                    RIX_TXADR: txaddr_q <= req.wdata;
                    RIX_TXCNT: begin
                        txgo_q   <= 1'b1;
                        txbase_q <= txaddr_q;
                        txlen_q  <= req.wdata;
                        txaddr_q <= txaddr_q + req.wdata;
                    end
                    RIX_RXADR: begin
                        rxaddr_q <= req.wdata;
                        cancel_q <= 1'b1;
                    end
                    RIX_RXCNT: begin
                        rxgo_q  <= 1'b1;
                        rxlen_q <= req.wdata;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign ien       = ien_q;
    assign tx_cmd    = '{go: txgo_q, addr: txbase_q, len: txlen_q};
    assign rx_cmd    = '{go: rxgo_q, addr: rxaddr_q, len: rxlen_q};
    assign rx_cancel = cancel_q;

endmodule

// File: rtl/sport_flow.sv
module sport_flow
    import sport_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic [IEN_W-1:0] ien,
    input  logic [CW-1:0]    level,
    input  logic [31:0]      rx_left,
    input  logic             rx_valid,
    output logic             push,
    output logic [31:0]      credit,
    output logic             irq
);
    logic dma_idle;

    assign dma_idle = (rx_left == 32'd0);
    assign push     = rx_valid && dma_idle;
    assign credit   = dma_idle ? (32'(DEPTH) - 32'(level)) : rx_left;
    assign irq      = irq_level(ien, level != '0, dma_idle);

endmodule

// File: rtl/sport_top.sv
module sport_top
    import sport_pkg::*;
#(
    parameter int          DEPTH    = 16,
    parameter logic [31:0] ID_VALUE = 32'h5E71_0001
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [11:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_rvalid,
    input  logic        rx_valid,
    input  logic [7:0]  rx_byte,
    output logic [31:0] rx_credit,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    output logic        dma_tx_go,
    output logic [31:0] dma_tx_addr,
    output logic [31:0] dma_tx_len,
    output logic        dma_rx_go,
    output logic [31:0] dma_rx_addr,
    output logic [31:0] dma_rx_len,
    output logic        dma_rx_cancel,
    input  logic [31:0] dma_rx_left,
    output logic        irq,
    output logic        rx_overflow
);
    localparam int CW = $clog2(DEPTH + 1);

    bus_req_t         req;
    logic [CW-1:0]    fifo_level;
    logic [31:0]      fifo_head;
    logic             fifo_pop;
    logic             fifo_push;
    logic [IEN_W-1:0] ien;
    dma_cmd_t         tx_cmd;
    dma_cmd_t         rx_cmd;
    logic             unused_lane;

    assign unused_lane = ^bus_addr[1:0];
    assign req = '{sel: bus_sel, wr: bus_wr, idx: bus_addr[11:2], wdata: bus_wdata};

    sport_rxq #(.DEPTH(DEPTH), .CW(CW)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .push      (fifo_push),
        .push_byte (rx_byte),
        .pop       (fifo_pop),
        .head      (fifo_head),
        .level     (fifo_level),
        .ovf       (rx_overflow)
    );

    sport_regs #(.DEPTH(DEPTH), .CW(CW), .ID_VALUE(ID_VALUE)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .level     (fifo_level),
        .head      (fifo_head),
        .rx_left   (dma_rx_left),
        .fifo_pop  (fifo_pop),
        .rdata     (bus_rdata),
        .rvalid    (bus_rvalid),
        .ien       (ien),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte),
        .tx_cmd    (tx_cmd),
        .rx_cmd    (rx_cmd),
        .rx_cancel (dma_rx_cancel)
    );

    sport_flow #(.DEPTH(DEPTH), .CW(CW)) u_flow (
        .ien      (ien),
        .level    (fifo_level),
        .rx_left  (dma_rx_left),
        .rx_valid (rx_valid),
        .push     (fifo_push),
        .credit   (rx_credit),
        .irq      (irq)
    );

    assign dma_tx_go   = tx_cmd.go;
    assign dma_tx_addr = tx_cmd.addr;
    assign dma_tx_len  = tx_cmd.len;
    assign dma_rx_go   = rx_cmd.go;
    assign dma_rx_addr = rx_cmd.addr;
    assign dma_rx_len  = rx_cmd.len;

endmodule

// File: rtl/sport_chk.sv
module sport_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [9:0]    bus_idx,
    input logic [31:0]   bus_wdata,
    input logic [31:0]   bus_rdata,
    input logic          bus_rvalid,
    input logic          rx_valid,
    input logic [31:0]   rx_credit,
    input logic [31:0]   dma_rx_left,
    input logic          tx_valid,
    input logic [7:0]    tx_byte,
    input logic          irq,
    input logic          rx_overflow,
    input logic [CW-1:0] level
);
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_idx == 10'd1 && level == '0) |=> (bus_rdata == 32'hFFFF_FFFF)); // R4

    AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr) |=> bus_rvalid); // R3

    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
        (level == $past(level)) || (level == $past(level) + 1'b1) || (level + 1'b1 == $past(level))); // R3

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        32'(level) <= 32'(DEPTH)); // R7

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
        rx_overflow |=> rx_overflow); // R7

    AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && dma_rx_left == 32'd0 && rx_credit == 32'd0) |=> rx_overflow); // R7

    AST_TX_ECHO: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_idx == 10'd1) |=> (tx_valid && tx_byte == $past(bus_wdata[7:0]))); // R8

    AST_TX_IRQ: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && bus_wr && bus_idx == 10'd3 && bus_wdata[1]) |=> irq); // R9

endmodule

bind sport_top sport_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_idx     (bus_addr[11:2]),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .bus_rvalid  (bus_rvalid),
    .rx_valid    (rx_valid),
    .rx_credit   (rx_credit),
    .dma_rx_left (dma_rx_left),
    .tx_valid    (tx_valid),
    .tx_byte     (tx_byte),
    .irq         (irq),
    .rx_overflow (rx_overflow),
    .level       (fifo_level)
);

// File: tb/test_sport_top.sv
module test_sport_top;
    localparam int          DEPTH = 16;
    localparam logic [31:0] IDV   = 32'h5E71_0001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic [31:0] rx_credit;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        dma_tx_go;
    logic [31:0] dma_tx_addr;
    logic [31:0] dma_tx_len;
    logic        dma_rx_go;
    logic [31:0] dma_rx_addr;
    logic [31:0] dma_rx_len;
    logic        dma_rx_cancel;
    logic [31:0] dma_rx_left = '0;
    logic        irq;
    logic        rx_overflow;

    always #10 clk = ~clk;

    sport_top #(.DEPTH(DEPTH), .ID_VALUE(IDV)) i_sport_top (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .rx_valid(rx_valid), .rx_byte(rx_byte),
        .rx_credit(rx_credit), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .dma_tx_go(dma_tx_go), .dma_tx_addr(dma_tx_addr), .dma_tx_len(dma_tx_len),
        .dma_rx_go(dma_rx_go), .dma_rx_addr(dma_rx_addr), .dma_rx_len(dma_rx_len),
        .dma_rx_cancel(dma_rx_cancel), .dma_rx_left(dma_rx_left),
        .irq(irq), .rx_overflow(rx_overflow)
    );

    int n_checks = 0;
    int n_fail   = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    logic [7:0]  q[$];
    logic [31:0] m_ien, m_rdata, m_txaddr, m_rxaddr, m_txlen, m_txbase, m_rxlen;
    logic        m_ovf, m_rvalid, m_txv, m_txgo, m_rxgo, m_cancel;
    logic [7:0]  m_txb;
    int          m_old;
    logic [9:0]  m_idx;

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            m_ien = 0; m_rdata = 0; m_txaddr = 0; m_rxaddr = 0; m_txlen = 0;
            m_txbase = 0; m_rxlen = 0; m_ovf = 0; m_rvalid = 0; m_txv = 0;
            m_txgo = 0; m_rxgo = 0; m_cancel = 0; m_txb = 0;
        end else begin
            m_old = q.size();
            m_idx = bus_addr[11:2];
            m_rvalid = bus_sel && !bus_wr;
            m_txv = 0; m_txgo = 0; m_rxgo = 0; m_cancel = 0;
            if (bus_sel && !bus_wr) begin
                case (m_idx)
                    10'd0: m_rdata = IDV;
                    10'd1: m_rdata = (m_old > 0) ? 32'(q.pop_front()) : 32'hFFFF_FFFF;
                    10'd2: m_rdata = 32'(m_old);
                    10'd3: m_rdata = m_ien;
                    10'd4: m_rdata = m_txaddr;
                    10'd5: m_rdata = 0;
                    10'd6: m_rdata = m_rxaddr;
                    10'd7: m_rdata = dma_rx_left;
                    10'd8: m_rdata = DEPTH;
                    default: m_rdata = 0;
                endcase
            end
            if (bus_sel && bus_wr) begin
                case (m_idx)
                    10'd1: begin m_txv = 1; m_txb = bus_wdata[7:0]; end
                    10'd3: m_ien = bus_wdata & 32'd7;
                    10'd4: m_txaddr = bus_wdata;
                    10'd5: begin
                        m_txgo = 1; m_txlen = bus_wdata; m_txbase = m_txaddr;
                        m_txaddr = m_txaddr + bus_wdata;
                    end
                    10'd6: begin m_rxaddr = bus_wdata; m_cancel = 1; end
                    10'd7: begin m_rxgo = 1; m_rxlen = bus_wdata; end
                    default: ;
                endcase
            end
            if (rx_valid && dma_rx_left == 0) begin
                if (m_old >= DEPTH) m_ovf = 1;
                else q.push_back(rx_byte);
            end
        end
    end

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        #5;
        if (!rst) begin
            chk("R9 irq", 32'(irq), 32'((m_ien[0] && q.size() > 0) || m_ien[1] ||
                                         (m_ien[2] && dma_rx_left == 0)));
            chk("R5 credit", rx_credit, (dma_rx_left != 0) ? dma_rx_left : 32'(DEPTH - q.size()));
            chk("R7 overflow", 32'(rx_overflow), 32'(m_ovf));
            chk("R3 rvalid", 32'(bus_rvalid), 32'(m_rvalid));
            chk("R8 tx_valid", 32'(tx_valid), 32'(m_txv));
            if (m_txv) chk("R8 tx_byte", 32'(tx_byte), 32'(m_txb));
            chk("R10 tx_go", 32'(dma_tx_go), 32'(m_txgo));
            if (m_txgo) begin
                chk("R10 tx_addr", dma_tx_addr, m_txbase);
                chk("R10 tx_len", dma_tx_len, m_txlen);
            end
            chk("R11 rx_go", 32'(dma_rx_go), 32'(m_rxgo));
            if (m_rxgo) chk("R11 rx_len", dma_rx_len, m_rxlen);
            chk("R11 cancel", 32'(dma_rx_cancel), 32'(m_cancel));
            chk("R11 rx_addr", dma_rx_addr, m_rxaddr);
        end
    end

    task automatic rd(input logic [9:0] idx, input string tag, output logic [31:0] val);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = {idx, 2'b00};
        @(posedge clk); #5;
        chk(tag, bus_rdata, m_rdata);
        val = bus_rdata;
        bus_sel = 0;
    endtask

    task automatic wr(input logic [9:0] idx, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = {idx, 2'b00}; bus_wdata = d;
        @(posedge clk); #5;
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1; rx_byte = b;
        @(posedge clk); #5;
        rx_valid = 0;
    endtask

    task automatic push_pop(input logic [7:0] b, input string tag, output logic [31:0] val);
        @(negedge clk);
        rx_valid = 1; rx_byte = b;
        bus_sel = 1; bus_wr = 0; bus_addr = {10'd1, 2'b00};
        @(posedge clk); #5;
        chk(tag, bus_rdata, m_rdata);
        val = bus_rdata;
        rx_valid = 0; bus_sel = 0;
    endtask

    task automatic set_left(input logic [31:0] v);
        @(negedge clk);
        dma_rx_left = v;
    endtask

    initial begin
        logic [31:0] v;
        logic [7:0]  nxt;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 credit", rx_credit, DEPTH);
        chk("R1 rvalid", 32'(bus_rvalid), 0);
        chk("R1 tx_valid", 32'(tx_valid), 0);
        chk("R1 overflow", 32'(rx_overflow), 0);
        chk("R1 dma pulses", 32'({dma_tx_go, dma_rx_go, dma_rx_cancel}), 0);
        rst = 0;
        #1;
        chk("R1 irq after release", 32'(irq), 0);
        chk("R1 credit after release", rx_credit, DEPTH);

        rd(10'd0, "R2 id", v);         chk("R2 id literal", v, IDV);
        rd(10'd8, "R2 cap", v);        chk("R2 cap literal", v, DEPTH);
        rd(10'd9, "R2 undefined", v);  chk("R2 undefined literal", v, 0);
        rd(10'h3FF, "R2 top idx", v);  chk("R2 top idx literal", v, 0);
        wr(10'd12, 32'hFFFF_FFFF);
        rd(10'd3, "R2 ien untouched", v);   chk("R2 ien literal", v, 0);
        rd(10'd2, "R2 level untouched", v); chk("R2 level literal", v, 0);
        chk("R2 irq untouched", 32'(irq), 0);

        rd(10'd1, "R4 empty read", v); chk("R4 empty literal", v, 32'hFFFF_FFFF);
        rd(10'd2, "R4 level after", v); chk("R4 level literal", v, 0);

        push(8'h11); push(8'h22); push(8'h33);
        rd(10'd2, "R5 level", v); chk("R5 level literal", v, 3);
        rd(10'd1, "R3 pop1", v); chk("R3 pop1 literal", v, 32'h11);
        rd(10'd1, "R3 pop2", v); chk("R3 pop2 literal", v, 32'h22);
        rd(10'd1, "R3 pop3", v); chk("R3 pop3 literal", v, 32'h33);

        wr(10'd3, 32'h1);
        push(8'h44);
        rd(10'd3, "R9 ien", v); chk("R9 ien literal", v, 1);
        rd(10'd1, "R3 pop4", v);
        wr(10'd3, 32'h2);
        wr(10'd3, 32'hFFFF_FFFC);
        rd(10'd3, "R9 ien mask", v); chk("R9 ien mask literal", v, 4);
        set_left(32'd5);
        push(8'h55); push(8'h56);
        rd(10'd2, "R6 level unchanged", v); chk("R6 level literal", v, 0);
        rd(10'd7, "R11 left read", v); chk("R11 left literal", v, 5);
        set_left(32'd0);

        wr(10'd3, 32'h0);
        for (int i = 0; i < DEPTH; i++) push(8'h80 + 8'(i));
        chk("R5 credit full", rx_credit, 0);
        push(8'hEE); push(8'hEF);
        rd(10'd2, "R7 level full", v); chk("R7 level literal", v, DEPTH);
        chk("R7 overflow set", 32'(rx_overflow), 1);
        push_pop(8'hED, "R7 pop while full", v); chk("R7 pop while full literal", v, 32'h80);
        for (int i = 1; i < DEPTH; i++) begin
            rd(10'd1, "R7 kept", v); chk("R7 kept literal", v, 32'(8'h80 + 8'(i)));
        end
        rd(10'd1, "R7 dropped gone", v); chk("R7 dropped literal", v, 32'hFFFF_FFFF);
        chk("R7 overflow sticky", 32'(rx_overflow), 1);

        for (int i = 0; i < 5; i++) push(8'(i));
        nxt = 0;
        for (int i = 5; i < 45; i++) begin
            push_pop(8'(i), "R12 wrap", v);
            chk("R12 wrap order", v, 32'(nxt));
            nxt++;
        end
        for (int i = 0; i < 5; i++) begin
            rd(10'd1, "R12 drain", v); chk("R12 drain order", v, 32'(nxt));
            nxt++;
        end

        wr(10'd1, 32'h0000_01A5);
        wr(10'd1, 32'h0000_003C);

        wr(10'd4, 32'h0000_1000);
        wr(10'd5, 32'h0000_0020);
        rd(10'd4, "R10 tx addr advanced", v); chk("R10 tx addr literal", v, 32'h1020);
        rd(10'd5, "R10 tx count reads zero", v); chk("R10 tx count literal", v, 0);

        wr(10'd6, 32'h0000_2000);
        rd(10'd6, "R11 rx addr", v); chk("R11 rx addr literal", v, 32'h2000);
        wr(10'd7, 32'd7);
        set_left(32'd9);
        rd(10'd7, "R11 rx left", v); chk("R11 rx left literal", v, 9);
        set_left(32'd0);

        repeat (3) @(posedge clk);
        #5;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule